// File: doc/BRIEF.md
# SHA-1 Compression Core

This block runs the SHA-1 compression function over a sequence of 512-bit blocks and keeps the 160-bit running digest. An external unit fetches and pads the message and expands the message schedule. It hands over one 32-bit schedule word per step, with a valid flag. The core retires one of the 80 steps on each clock in which a word is accepted. A stall, meaning a cycle with the valid flag low, leaves everything unchanged.

A pulse on the init input starts a new message. It returns the digest to the SHA-1 initial value and discards any partly processed block. After the 80th word of a block, the core spends one cycle folding the working variables into the digest, and the source leaves that cycle empty. If the last flag came with the 80th word, a one-cycle done pulse marks the final hash. The hash then stays unchanged until the next init.

Top module: `sha1_core`

## Requirements
- R1: After an active-low reset, `hash_o` equals 67452301_efcdab89_98badcfe_10325476_c3d2e1f0 (hex, first word in bits 159:128) and `done_o` is low.
- R2: A cycle with `init_i` high returns the digest to the R1 value and the step count to 0, so that any partial block is discarded. A word offered in that cycle is not accepted.
- R3: Each cycle with `w_valid_i` high (outside init and fold cycles) retires exactly one step. A cycle with `w_valid_i` low changes no state.
- R4: Steps 0-19 use constant 5a827999 with the choose function (B and C) or (not B and D). Steps 20-39 use 6ed9eba1 with B xor C xor D. Steps 40-59 use 8f1bbcdc with the majority of B, C and D. Steps 60-79 use ca62c1d6 with B xor C xor D.
- R5: Each step computes T = rotl(A,5)+F+E+W+K modulo 2^32, then sets (A,B,C,D,E) to (T, A, rotl(B,30), C, D). Step 0 of every block starts from the current digest words.
- R6: The cycle after the 80th accepted word is a fold cycle. In it, A..E are added modulo 2^32 into digest words 0..4, and a word offered in that cycle is ignored.
- R7: `last_i` is sampled only together with the 80th word of a block. If it is high, `done_o` is high for exactly the one cycle after the fold edge, and `hash_o` then shows the updated digest with word 0 in the most significant bits.
- R8: After `done_o`, `hash_o` holds its value while no words arrive, until the next init or reset.
- R9: The padded single block of the 43-byte ASCII text "The quick brown fox jumps over the lazy dog" yields 2fd4e1c6_7a2d28fc_ed849ee1_bb76e739_1b93eb12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous |
| init_i | input | 1 | Start a new message: digest to initial value, step count cleared |
| w_valid_i | input | 1 | Schedule word present this cycle |
| w_i | input | 32 | Schedule word W for the current step |
| last_i | input | 1 | With the 80th word: this block ends the message |
| hash_o | output | 160 | Running digest, H0 in bits 159:128 |
| done_o | output | 1 | One-cycle pulse when the final digest is ready |

## Verification
A wrong step constant, logic function or rotation stays inside the working registers until the fold cycle. It then shows as a corrupted `hash_o` word on the cycle `done_o` rises, 81 cycles after the first word at the soonest. A wrong step count shows up in the same way, or as `done_o` appearing at the wrong cycle. A bad chaining between blocks is only visible in messages of two or more blocks. For that reason, multi-block random messages with stalls and junk words in the fold cycle are compared against an independent bench model of the block function.

// File: rtl/sha1_pkg.sv
package sha1_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 5;
  localparam int STEPS     = 80;
  localparam int PHASE_LEN = 20;
  localparam int STEP_W    = $clog2(STEPS);

  typedef struct packed {
    logic [WORD_W-1:0] a;
    logic [WORD_W-1:0] b;
    logic [WORD_W-1:0] c;
    logic [WORD_W-1:0] d;
    logic [WORD_W-1:0] e;
  } sha1_state_t;

  localparam sha1_state_t IV = '{
    a: 32'h67452301, b: 32'hefcdab89, c: 32'h98badcfe,
    d: 32'h10325476, e: 32'hc3d2e1f0
  };

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic logic [1:0] phase_of(input logic [STEP_W-1:0] s);
    if (s < STEP_W'(PHASE_LEN))            return 2'd0;
    else if (s < STEP_W'(2 * PHASE_LEN))   return 2'd1;
    else if (s < STEP_W'(3 * PHASE_LEN))   return 2'd2;
    else                                   return 2'd3;
  endfunction

  function automatic logic [WORD_W-1:0] k_of(input logic [1:0] ph);
    case (ph)
      2'd0:    return 32'h5a827999;
      2'd1:    return 32'h6ed9eba1;
      2'd2:    return 32'h8f1bbcdc;
      default: return 32'hca62c1d6;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] f_of(input logic [1:0] ph,
      input logic [WORD_W-1:0] b, input logic [WORD_W-1:0] c, input logic [WORD_W-1:0] d);
    case (ph)
      2'd0:    return (b & c) | (~b & d);
      2'd2:    return (b & c) | (b & d) | (c & d);
      default: return b ^ c ^ d;
    endcase
  endfunction

  function automatic sha1_state_t step_fn(input sha1_state_t s,
      input logic [WORD_W-1:0] w, input logic [1:0] ph);
    sha1_state_t n;
    n.a = rotl(s.a, 5) + f_of(ph, s.b, s.c, s.d) + s.e + w + k_of(ph);
    n.b = s.a;
    n.c = rotl(s.b, 30);
    n.d = s.c;
    n.e = s.d;
    return n;
  endfunction
endpackage

// File: rtl/sha1_ctrl.sv
module sha1_ctrl
  import sha1_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              w_valid_i,
  input  logic              last_i,
  output logic              take_o,
  output logic [STEP_W-1:0] step_o,
  output logic [1:0]        phase_o,
  output logic              fold_o,
  output logic              done_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  logic [STEP_W-1:0] step_q;
  logic fold_q, last_q, done_q;
  logic end_of_block;

  assign take_o       = w_valid_i & ~fold_q & ~init_i;
  assign end_of_block = take_o & (step_q == LAST_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      fold_q <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fold_q & last_q & ~init_i;
      if (init_i) begin
        step_q <= '0;
        fold_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        fold_q <= end_of_block;
        if (end_of_block) last_q <= last_i;
        if (take_o) step_q <= end_of_block ? '0 : step_q + 1'b1;
      end
    end
  end

  assign step_o  = step_q;
  assign phase_o = phase_of(step_q);
  assign fold_o  = fold_q;
  assign done_o  = done_q;

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step_q < STEP_W'(STEPS)); // R3
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!w_valid_i && !init_i && !fold_q) |=> $stable(step_q)); // R3
  AST_FOLD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && step_q == LAST_STEP) |=> (fold_o && step_o == '0)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
endmodule

// File: rtl/sha1_digest.sv
module sha1_digest
  import sha1_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_i,
  input  logic        fold_i,
  input  sha1_state_t work_i,
  output sha1_state_t digest_o
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] iv_w, work_w;
  logic [WORD_W-1:0] h_q [NUM_WORDS];

  assign iv_w   = IV;
  assign work_w = work_i;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      h_q[i] <= iv_w[i];
      else if (init_i) h_q[i] <= iv_w[i];
      else if (fold_i) h_q[i] <= h_q[i] + work_w[i];
    end
  end

  always_comb begin
    logic [NUM_WORDS-1:0][WORD_W-1:0] tmp;
    for (int i = 0; i < NUM_WORDS; i++) tmp[i] = h_q[i];
    digest_o = tmp;
  end

  AST_IV_ON_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (digest_o == IV)); // R2
  AST_HOLD_OUTSIDE_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !fold_i) |=> $stable(digest_o)); // R6
endmodule

// File: rtl/sha1_round.sv
module sha1_round
  import sha1_pkg::*;
(
  input  sha1_state_t       state_i,
  input  logic [WORD_W-1:0] w_i,
  input  logic [1:0]        phase_i,
  output sha1_state_t       state_o
);
  assign state_o = step_fn(state_i, w_i, phase_i);
endmodule

// File: rtl/sha1_core.sv
module sha1_core
  import sha1_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic         w_valid_i,
  input  logic [31:0]  w_i,
  input  logic         last_i,
  output logic [159:0] hash_o,
  output logic         done_o
);
  logic              take;
  logic [STEP_W-1:0] step;
  logic [1:0]        phase;
  logic              fold;
  sha1_state_t       digest, work_q, src, nxt;

  sha1_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .w_valid_i(w_valid_i),
    .last_i(last_i), .take_o(take), .step_o(step), .phase_o(phase),
    .fold_o(fold), .done_o(done_o)
  );

  sha1_digest u_digest (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .fold_i(fold),
    .work_i(work_q), .digest_o(digest)
  );

  // step 0 reads the digest directly, so no separate load cycle is needed
  assign src = (step == '0) ? digest : work_q;

  sha1_round u_round (
    .state_i(src), .w_i(w_i), .phase_i(phase), .state_o(nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    work_q <= IV;
    else if (take) work_q <= nxt;
  end

  assign hash_o = digest;

  AST_HASH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !init_i && !w_valid_i) |=> $stable(hash_o)); // R8
  AST_DONE_AFTER_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(fold)); // R7
endmodule

// File: tb/tb_sha1_core.sv
module tb_sha1_core;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         init_i = 1'b0;
  logic         w_valid_i = 1'b0;
  logic [31:0]  w_i = '0;
  logic         last_i = 1'b0;
  logic [159:0] hash_o;
  logic         done_o;

  int errors = 0;
  int checks = 0;
  localparam logic [159:0] INIT_H = 160'h67452301_efcdab89_98badcfe_10325476_c3d2e1f0;

  always #2.5 clk = ~clk;

  sha1_core dut (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .w_valid_i(w_valid_i),
    .w_i(w_i), .last_i(last_i), .hash_o(hash_o), .done_o(done_o)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] sched(input logic [511:0] m, input int t);
    logic [31:0] w [80];
    for (int i = 0; i < 80; i++)
      w[i] = (i < 16) ? m[511 - 32*i -: 32]
                      : rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    return w[t];
  endfunction

  function automatic logic [159:0] ref_block(input logic [159:0] h, input logic [511:0] m);
    logic [31:0] a, b, c, d, e, f, k, tmp;
    a = h[159:128]; b = h[127:96]; c = h[95:64]; d = h[63:32]; e = h[31:0];
    for (int t = 0; t < 80; t++) begin
      case (t / 20)
        0: begin f = (b & c) | (~b & d);          k = 32'h5a827999; end
        1: begin f = b ^ c ^ d;                   k = 32'h6ed9eba1; end
        2: begin f = (b & c) | (b & d) | (c & d); k = 32'h8f1bbcdc; end
        default: begin f = b ^ c ^ d;             k = 32'hca62c1d6; end
      endcase
      tmp = rl(a, 5) + f + e + k + sched(m, t);
      e = d; d = c; c = rl(b, 30); b = a; a = tmp;
    end
    return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
  endfunction

  function automatic logic [511:0] pad1(input string s);
    logic [511:0] m = '0;
    for (int i = 0; i < s.len(); i++) m[511 - 8*i -: 8] = s[i];
    m[511 - 8*s.len()] = 1'b1;
    m[63:0] = 64'(s.len() * 8);
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_init();
    @(negedge clk); init_i = 1'b1; w_valid_i = 1'b0;
    @(negedge clk); init_i = 1'b0;
  endtask

  // feeds 80 words; returns at the negedge right after the fold edge
  task automatic feed(input logic [511:0] m, input bit last, input bit stalls, input bit junk);
    for (int t = 0; t < 80; t++) begin
      if (stalls && ($urandom % 4 == 0)) begin
        @(negedge clk); w_valid_i = 1'b0; w_i = $urandom; last_i = $urandom;
      end
      @(negedge clk);
      w_valid_i = 1'b1; w_i = sched(m, t);
      last_i = (t == 79) ? last : 1'($urandom);
    end
    @(negedge clk); w_valid_i = junk; w_i = $urandom; last_i = 1'b0;
    @(negedge clk); w_valid_i = 1'b0;
  endtask

  task automatic run_msg(input int nblk, input bit stalls, input bit junk, input string req);
    logic [159:0] h = INIT_H;
    logic [511:0] m;
    do_init();
    for (int bi = 0; bi < nblk; bi++) begin
      m = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
           $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      h = ref_block(h, m);
      feed(m, bi == nblk - 1, stalls, junk);
      check(done_o == (bi == nblk - 1), {req, " done"}, 160'(done_o), 160'(bi == nblk - 1));
    end
    check(hash_o == h, req, hash_o, h);
  endtask

  initial begin
    logic [159:0] exp, held;
    void'($urandom(32'd1234));
    #12 @(negedge clk);
    check(hash_o == INIT_H && !done_o, "R1 reset state", hash_o, INIT_H);
    rst_n = 1'b1;

    // R9 known text; R4 R5 single block
    do_init();
    feed(pad1("The quick brown fox jumps over the lazy dog"), 1'b1, 1'b0, 1'b0);
    exp = 160'h2fd4e1c6_7a2d28fc_ed849ee1_bb76e739_1b93eb12;
    check(done_o == 1'b1, "R7 done on last block", 160'(done_o), 160'd1);
    check(hash_o == exp, "R9 known digest", hash_o, exp);
    @(negedge clk);
    check(done_o == 1'b0, "R7 done single cycle", 160'(done_o), 160'd0);
    held = hash_o;
    repeat (10) @(negedge clk);
    check(hash_o == held, "R8 hash holds after done", hash_o, held);

    // R4 "abc" with stalls (R3) and junk in fold cycle (R6)
    do_init();
    feed(pad1("abc"), 1'b1, 1'b1, 1'b1);
    exp = 160'ha9993e36_4706816a_ba3e2571_7850c26c_9cd0d89d;
    check(hash_o == exp, "R4 R3 R6 abc with stalls and junk", hash_o, exp);

    // R2 abort mid-block then restart
    do_init();
    for (int t = 0; t < 30; t++) begin
      @(negedge clk); w_valid_i = 1'b1; w_i = $urandom;
    end
    @(negedge clk); init_i = 1'b1; w_i = $urandom;
    @(negedge clk); init_i = 1'b0; w_valid_i = 1'b0;
    check(hash_o == INIT_H, "R2 init restores IV", hash_o, INIT_H);
    feed(pad1("abc"), 1'b1, 1'b0, 1'b0);
    check(hash_o == exp, "R2 partial block discarded", hash_o, exp);

    // R5 R6 multi-block chaining, random
    run_msg(2, 1'b0, 1'b0, "R5 two blocks");
    run_msg(3, 1'b1, 1'b1, "R5 R6 three blocks stalls junk");
    for (int i = 0; i < 4; i++) run_msg(1 + ($urandom % 3), 1'($urandom), 1'($urandom), "R4 R5 random message");

    // R1 reset mid-run
    do_init();
    for (int t = 0; t < 50; t++) begin
      @(negedge clk); w_valid_i = 1'b1; w_i = $urandom;
    end
    rst_n = 1'b0; w_valid_i = 1'b0;
    @(negedge clk);
    check(hash_o == INIT_H && !done_o, "R1 reset mid-run", hash_o, INIT_H);
    rst_n = 1'b1;
    feed(pad1("abc"), 1'b1, 1'b0, 1'b0);
    check(hash_o == exp, "R1 clean block after reset", hash_o, exp);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #900000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule